// File: doc/BRIEF.md
# Bus Slot Setup Select Controller

This block sits on the system board and holds two byte-wide configuration registers that the host reaches through I/O space. One is the system setup register at address 94h. The other is the adapter setup register at 96h. From the stored bits it drives a set of active-low setup-select lines:

- one line per expansion slot, eight slots in all;
- one line for the on-board video function;
- one line for the remaining on-board functions.

It also drives a level channel-reset output. Software uses the block to pick which single device answers the shared setup window at 100h–107h. The block never answers that window itself. It only flags that an access to the window is under way, so that the device in setup can take it.

The host side is a valid/ready request channel: valid, write flag, address and write data. A request is taken on any clock edge where both host_valid and host_ready are high. host_ready is low only during reset and for the first cycle after reset, so the block back-pressures the host only then. An accepted read of 94h or 96h returns one response beat on the following cycle: rsp_valid goes high for exactly one cycle with rsp_rdata. The response channel has no ready, so the host must take the response in that cycle. Accesses to any other address are ignored and give no response.

Top module: `slot_setup_ctrl`

## Requirements
- R1: After reset, 94h reads A0h, 96h reads 70h, every setup line is high, and chan_reset is low.
- R2: The board setup line board_setup_n carries bit 7 of register 94h: writing that bit 0 drives the line low, and writing it 1 drives it high.
- R3: The video setup line video_setup_n carries bit 5 of register 94h: writing that bit 0 drives the line low, and writing it 1 drives it high.
- R4: When 96h holds bit 7 = 0 and bit 3 = 1, card_setup_n[k] is low for k = the value of bits 2:0, and all other slot lines are high. Code 000 is slot 1 at index 0, and code 111 is slot 8 at index 7. At most one slot line is ever low.
- R5: When 96h holds bit 3 = 0, all card_setup_n lines are high, whatever bits 2:0 hold.
- R6: When 96h holds bit 7 = 1, chan_reset is high and all card_setup_n lines are high, whatever bits 3:0 hold. chan_reset stays high until 96h is written with bit 7 = 0.
- R7: A read of 94h returns the stored byte. A read of 96h returns the stored byte OR 70h, so bits 6:4 always read 1. The response arrives with rsp_valid high for one cycle, on the cycle after the read is accepted.
- R8: Setup outputs and chan_reset change on the second rising edge after the edge that accepts the write. They are unchanged in the cycle between those two edges.
- R9: pos_space_sel is high, combinationally, while host_valid is high and host_addr lies in 100h–107h. Such accesses, and accesses to any address other than 94h and 96h, change no register and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | I/O address |
| host_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_rdata | output | 8 | Read response data |
| pos_space_sel | output | 1 | Request targets the shared setup window |
| card_setup_n | output | 8 | Active-low setup line per slot |
| video_setup_n | output | 1 | Active-low video setup line |
| board_setup_n | output | 1 | Active-low on-board function setup line |
| chan_reset | output | 1 | Channel reset level |

## Verification
The assertions check the following on every cycle:
- no more than one slot line is low;
- a raised channel reset silences every slot line;
- a cleared adapter-select bit leaves every slot line high;
- each response beat follows an accepted register read;
- each 96h response carries bits 6:4 set.

The bench's scenarios are needed for the rest:
- the exact slot chosen by each code;
- the two-edge write latency;
- the reset values;
- the behaviour of writes that must leave the registers untouched.

To cover these, the bench sweeps all 256 values through both registers.

// File: rtl/slot_setup_pkg.sv
package slot_setup_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SYS  = 2'd1,
    ACC_ADP  = 2'd2,
    ACC_WIN  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/slot_host_port.sv
module slot_host_port
  import slot_setup_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SYS_ADDR = 16'h0094,
  parameter logic [ADDR_W-1:0] ADP_ADDR = 16'h0096,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0100,
  parameter int WIN_SPAN = 8,
  parameter logic [DATA_W-1:0] SYS_RST = 8'hA0,
  parameter logic [DATA_W-1:0] ADP_RST = 8'h00,
  parameter logic [DATA_W-1:0] ADP_RD_ONES = 8'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              pos_space_sel,
  output logic [DATA_W-1:0] sys_reg,
  output logic [DATA_W-1:0] adp_reg
);

  localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(WIN_SPAN);

  acc_kind_e   kind;
  logic        accept;
  logic        ready_q;
  logic        in_win;
  logic        rd_hit;
  logic        last_adp;

  assign in_win = ({1'b0, host_addr} >= WIN_LO) && ({1'b0, host_addr} < WIN_HI);

  always_comb begin
    if (host_addr == SYS_ADDR)      kind = ACC_SYS;
    else if (host_addr == ADP_ADDR) kind = ACC_ADP;
    else if (in_win)                kind = ACC_WIN;
    else                            kind = ACC_NONE;
  end

  assign host_ready    = ready_q;
  assign accept        = host_valid && ready_q;
  assign rd_hit        = accept && !host_write && (kind == ACC_SYS || kind == ACC_ADP);
  assign pos_space_sel = host_valid && (kind == ACC_WIN);

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_reg <= SYS_RST;
      adp_reg <= ADP_RST;
    end else if (accept && host_write) begin
      if (kind == ACC_SYS) sys_reg <= host_wdata;
      if (kind == ACC_ADP) adp_reg <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      last_adp  <= 1'b0;
    end else begin
      rsp_valid <= rd_hit;
      last_adp  <= rd_hit && (kind == ACC_ADP);
      if (rd_hit) begin
        if (kind == ACC_ADP) rsp_rdata <= adp_reg | ADP_RD_ONES;
        else                 rsp_rdata <= sys_reg;
      end
    end
  end

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(accept && !host_write)) else $error("rsp without read"); // R7

  AST_ADP_ONES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && last_adp) |-> ((rsp_rdata & ADP_RD_ONES) == ADP_RD_ONES))
    else $error("adapter readback ones"); // R7

  AST_WIN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (accept && host_write && pos_space_sel) |=> ($stable(sys_reg) && $stable(adp_reg)))
    else $error("window write touched register"); // R9

endmodule

// File: rtl/slot_onehot_dec.sv
module slot_onehot_dec #(
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 8,
  parameter int ENA_BIT   = 3,
  parameter int RST_BIT   = 7,
  localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
  input  logic [DATA_W-1:0]    adp_reg,
  output logic [NUM_SLOTS-1:0] slot_sel
);

  logic             gate;
  logic [SEL_W-1:0] code;

  assign gate = adp_reg[ENA_BIT] && !adp_reg[RST_BIT];
  assign code = adp_reg[SEL_W-1:0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_sel[i] = gate && (code == SEL_W'(i));
  end

endmodule

// File: rtl/slot_setup_drive.sv
module slot_setup_drive #(
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 8,
  parameter int ENA_BIT   = 3,
  parameter int RST_BIT   = 7,
  parameter int VID_BIT   = 5,
  parameter int BRD_BIT   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    sys_reg,
  input  logic [DATA_W-1:0]    adp_reg,
  input  logic [NUM_SLOTS-1:0] slot_sel,
  output logic [NUM_SLOTS-1:0] card_setup_n,
  output logic                 video_setup_n,
  output logic                 board_setup_n,
  output logic                 chan_reset
);

  always_ff @(posedge clk) begin
    if (rst) begin
      card_setup_n  <= '1;
      video_setup_n <= 1'b1;
      board_setup_n <= 1'b1;
      chan_reset    <= 1'b0;
    end else begin
      card_setup_n  <= ~slot_sel;
      video_setup_n <= sys_reg[VID_BIT];
      board_setup_n <= sys_reg[BRD_BIT];
      chan_reset    <= adp_reg[RST_BIT];
    end
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~card_setup_n)) else $error("multiple slots in setup"); // R4

  AST_RESET_QUIETS: assert property (@(posedge clk) disable iff (rst)
    chan_reset |-> (&card_setup_n)) else $error("slot line during channel reset"); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !adp_reg[ENA_BIT] |=> (&card_setup_n)) else $error("slot line while adapter select clear"); // R5

endmodule

// File: rtl/slot_setup_ctrl.sv
module slot_setup_ctrl
  import slot_setup_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_valid,
  output logic                 host_ready,
  input  logic                 host_write,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 pos_space_sel,
  output logic [NUM_SLOTS-1:0] card_setup_n,
  output logic                 video_setup_n,
  output logic                 board_setup_n,
  output logic                 chan_reset
);

  logic [DATA_W-1:0]    sys_reg;
  logic [DATA_W-1:0]    adp_reg;
  logic [NUM_SLOTS-1:0] slot_sel;

  slot_host_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_port (
    .clk           (clk),
    .rst           (rst),
    .host_valid    (host_valid),
    .host_ready    (host_ready),
    .host_write    (host_write),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .pos_space_sel (pos_space_sel),
    .sys_reg       (sys_reg),
    .adp_reg       (adp_reg)
  );

  slot_onehot_dec #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_dec (
    .adp_reg  (adp_reg),
    .slot_sel (slot_sel)
  );

  slot_setup_drive #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_drive (
    .clk           (clk),
    .rst           (rst),
    .sys_reg       (sys_reg),
    .adp_reg       (adp_reg),
    .slot_sel      (slot_sel),
    .card_setup_n  (card_setup_n),
    .video_setup_n (video_setup_n),
    .board_setup_n (board_setup_n),
    .chan_reset    (chan_reset)
  );

endmodule

// File: tb/tb_slot_setup_ctrl.sv
`timescale 1ns/1ps
module tb_slot_setup_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        pos_space_sel;
  logic [7:0]  card_setup_n;
  logic        video_setup_n;
  logic        board_setup_n;
  logic        chan_reset;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rd_val;
  logic       rd_ok;

  always #10 clk = ~clk;

  slot_setup_ctrl dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    rd_ok  = rsp_valid;
    rd_val = rsp_rdata;
  endtask

  function automatic logic [7:0] exp_card(input logic [7:0] v);
    if (!v[7] && v[3]) return ~(8'h01 << v[2:0]);
    return 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 card", card_setup_n, 8'hFF);
    check("R1 video", video_setup_n, 1);
    check("R1 board", board_setup_n, 1);
    check("R1 chrst", chan_reset, 0);
    check("R1 ready", host_ready, 1);
    rd(16'h0094); check("R1 rd94", {rd_ok, rd_val}, {1'b1, 8'hA0});
    rd(16'h0096); check("R1 rd96", {rd_ok, rd_val}, {1'b1, 8'h70});

    // R8 latency: outputs unchanged one cycle after accept, updated after second edge
    wr(16'h0096, 8'h0B);
    check("R8 hold", card_setup_n, 8'hFF);
    @(negedge clk);
    check("R8 card", card_setup_n, 8'hF7);

    // R4 R5 R6 R7 sweep all adapter values
    for (int v = 0; v < 256; v++) begin
      wr(16'h0096, 8'(v));
      @(negedge clk);
      check("R4/R5 card", card_setup_n, exp_card(8'(v)));
      check("R6 chrst", chan_reset, v[7]);
      rd(16'h0096);
      check("R7 rd96", {rd_ok, rd_val}, {1'b1, 8'(v) | 8'h70});
    end

    // R2 R3 R7 sweep all system values
    for (int v = 0; v < 256; v++) begin
      wr(16'h0094, 8'(v));
      @(negedge clk);
      check("R2 board", board_setup_n, v[7]);
      check("R3 video", video_setup_n, v[5]);
      rd(16'h0094);
      check("R7 rd94", {rd_ok, rd_val}, {1'b1, 8'(v)});
    end

    // R6 channel reset persists then clears
    wr(16'h0096, 8'h8F);
    @(negedge clk);
    check("R6 set", {chan_reset, card_setup_n}, {1'b1, 8'hFF});
    wr(16'h0095, 8'h00);
    @(negedge clk);
    check("R6 held", chan_reset, 1);
    wr(16'h0096, 8'h0A);
    @(negedge clk);
    check("R6 clear", {chan_reset, card_setup_n}, {1'b0, 8'hFB});

    // R9 window and unmapped accesses
    wr(16'h0094, 8'h5A);
    for (int a = 16'h00FE; a < 16'h010A; a++) begin
      @(negedge clk);
      host_valid = 1'b1; host_write = 1'b1; host_addr = 16'(a); host_wdata = 8'h33;
      #1;
      check("R9 sel", pos_space_sel, (a >= 16'h100 && a < 16'h108));
      @(negedge clk);
      host_valid = 1'b0;
      check("R9 no rsp", rsp_valid, 0);
    end
    rd(16'h0102); check("R9 win rd", rd_ok, 0);
    rd(16'h0095); check("R9 unmapped rd", rd_ok, 0);
    rd(16'h0094); check("R9 sys kept", rd_val, 8'h5A);
    rd(16'h0096); check("R9 adp kept", rd_val, 8'h7A);
    @(negedge clk);
    check("R9 lines kept", {board_setup_n, video_setup_n, card_setup_n}, {1'b0, 1'b0, 8'hFB});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule